// File: doc/BRIEF.md
# Masked Region Bus Address Decoder

This block sits between a 32-bit byte-addressed processor bus and a small set of slave regions. Each region is described at build time by a base, a mask and four permission bits (read, write, execute, image-load). For every request the decoder picks the first region whose masked address equals its base. It turns the address into a region-local offset and grants the access only when the region's permissions allow that kind of access. The slaves see plain word ports: a one-hot select, a write enable, the offset, replicated write data and byte strobes.

Sub-word traffic is big-endian: byte address 0 lives in bits 31:24 of a word. Loads of bytes and halfwords pick their lane out of the word that the slave returns. Stores copy the byte or halfword into every lane and raise only the strobes of the addressed lanes. Any unmapped or forbidden access gets an error response and sets a sticky error flag. Software reads that flag through a read strobe, and the read also clears it.

Decode is combinational in the request cycle. The slaves register their read data. The response (valid, error, steered data) appears in the following cycle.

Top module: `bus_region_decoder`

## Requirements
- R1: A region i matches when (req_addr AND mask[i]) equals base[i]. The lowest-numbered matching region wins, and a granted access raises only bit i of slv_sel.
- R2: slv_offset is req_addr AND NOT mask of the chosen region. Bits 1:0 are cleared for word size (req_size 2 or 3), bit 0 is cleared for halfword size (1), and byte size (0) is left as is. With no matching region slv_offset is 0.
- R3: A request that matches no region selects no slave and gets an error response whose data is zero.
- R4: req_kind encodes 0 read, 1 write, 2 fetch and 3 image load. A write needs permission bit 1, a fetch needs bit 2 and an image load needs bit 3; a read needs no permission. A request without its permission selects no slave, writes nothing and gets an error response.
- R5: A byte load returns the slave word shifted right by 8*(3 - addr[1:0]), keeping the low 8 bits and zero-extended. Byte address 0 is therefore bits 31:24.
- R6: A halfword load returns bits 31:16 when addr[1] is 0 and bits 15:0 when it is 1, zero-extended.
- R7: slv_wdata carries the low byte of req_wdata in all four lanes for byte stores, the low halfword in both halves for halfword stores, and req_wdata unchanged for word stores.
- R8: slv_be bit 3 covers bits 31:24. A byte store raises bit 3-addr[1:0]; a halfword store raises 1100 when addr[1] is 0 and 0011 when it is 1; a word store raises 1111. slv_be is 0000 and slv_we is 0 for reads, fetches and refused accesses.
- R9: rsp_valid is high exactly in the cycle after each request cycle, together with rsp_err. For granted reads and fetches rsp_data is the steered slave data; for writes it is zero.
- R10: Every error response sets a sticky flag. The cycle after err_read, err_rdata shows the flag as it was before the read, and the flag is cleared. An error in the same cycle as the read leaves the flag set.
- R11: After reset rsp_valid and err_rdata are 0 and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 image load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| slv_sel | output | 4 | One-hot slave select for granted accesses |
| slv_we | output | 1 | Write enable for the selected slave |
| slv_offset | output | 32 | Region-local, size-aligned offset |
| slv_wdata | output | 32 | Lane-replicated store data |
| slv_be | output | 4 | Byte strobes, bit 3 = bits 31:24 |
| slv_rdata | input | 128 | Registered read data, slave i at bits 32*i+31:32*i |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was unmapped or refused |
| rsp_data | output | 32 | Steered load or fetch data |
| err_read | input | 1 | Read and clear the sticky error flag |
| err_rdata | output | 1 | Flag value returned by the previous err_read |

## Verification
A wrong priority or mask compare shows up in the same cycle as a wrong slv_sel or slv_offset. Wrong permissions show up as a select that appears or disappears. A mistake in lane or strobe logic is visible in the request cycle on slv_wdata and slv_be. It also shows later, when a read of the word returns the wrong bytes. A fault in the response registers or the sticky flag appears one cycle after the request or the err_read strobe. The bench therefore checks the select outputs in the request cycle and the response in the next cycle, and it reads the memory back after every store.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  typedef enum logic [1:0] {
    ACC_READ    = 2'd0,
    ACC_WRITE   = 2'd1,
    ACC_FETCH   = 2'd2,
    ACC_IMGLOAD = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int PERM_W = 4;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;
  localparam int PERM_LD = 3;
endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter int AW   = 32,
  parameter int NREG = 4,
  parameter int IW   = 2,
  parameter logic [NREG-1:0][AW-1:0] BASES = '0,
  parameter logic [NREG-1:0][AW-1:0] MASKS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [NREG-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_cmp
      assign match[g] = ((addr & MASKS[g]) == BASES[g]);
    end
  endgenerate

  // lowest index has priority: scan from the top so it is assigned last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // R1: the reported region really satisfies its compare
  assert_hit_consistent_R1: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((addr & MASKS[idx]) == BASES[idx]));

  // R1: no region matching means no hit
  assert_miss_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (match == '0) |-> !hit);
endmodule

// File: rtl/wr_lanes.sv
module wr_lanes
  import bus_dec_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int LW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  acc_size_e     size,
  input  logic [LW-1:0] lo,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [NB-1:0] be
);
  logic [LW-2:0] half_idx;
  assign half_idx = lo[LW-1:1];

  always_comb begin
    case (size)
      SZ_BYTE: dout = {NB{din[7:0]}};
      SZ_HALF: dout = {(NB/2){din[15:0]}};
      default: dout = din;
    endcase
  end

  // big-endian strobes: lane NB-1 holds byte address 0
  always_comb begin
    be = '0;
    if (en) begin
      case (size)
        SZ_BYTE: be = NB'(1) << (NB - 1 - int'(lo));
        SZ_HALF: be = NB'(3) << (NB - 2 - 2 * int'(half_idx));
        default: be = '1;
      endcase
    end
  end

  // R8: an enabled store raises one, two or all lanes
  assert_be_width_R8: assert property (@(posedge clk) disable iff (rst)
    en |-> ($countones(be) == 1 || $countones(be) == 2 || $countones(be) == NB));

  // R8: strobes stay low when no store is granted
  assert_be_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (be == '0));
endmodule

// File: rtl/rd_lanes.sv
module rd_lanes
  import bus_dec_pkg::*;
#(
  parameter int DW = 32,
  parameter int NB = DW / 8,
  parameter int LW = $clog2(NB)
) (
  input  acc_size_e     size,
  input  logic [LW-1:0] lo,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] dout
);
  logic [7:0]    byte_val;
  logic [15:0]   half_val;
  logic [LW-2:0] half_idx;

  assign half_idx = lo[LW-1:1];
  assign byte_val = 8'(word >> (8 * (NB - 1 - int'(lo))));
  assign half_val = 16'(word >> (16 * (NB / 2 - 1 - int'(half_idx))));

  always_comb begin
    case (size)
      SZ_BYTE: dout = {{(DW-8){1'b0}}, byte_val};
      SZ_HALF: dout = {{(DW-16){1'b0}}, half_val};
      default: dout = word;
    endcase
  end
endmodule

// File: rtl/bus_region_decoder.sv
module bus_region_decoder
  import bus_dec_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 4,
  parameter logic [NREG-1:0][AW-1:0] REG_BASE =
    {32'h1000_0000, 32'h0100_0000, 32'h0002_0000, 32'h0000_0150},
  parameter logic [NREG-1:0][AW-1:0] REG_MASK =
    {32'hF000_0000, 32'hFF00_0000, 32'h07FE_0000, 32'hFFFF_FFF0},
  parameter logic [NREG-1:0][3:0] REG_PERM =
    {4'b0111, 4'b1101, 4'b0111, 4'b0011}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [NREG-1:0]  slv_sel,
  output logic             slv_we,
  output logic [AW-1:0]    slv_offset,
  output logic [DW-1:0]    slv_wdata,
  output logic [DW/8-1:0]  slv_be,
  input  logic [NREG*DW-1:0] slv_rdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_data,
  input  logic             err_read,
  output logic             err_rdata
);
  localparam int NB = DW / 8;
  localparam int LW = $clog2(NB);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  acc_kind_e kind;
  acc_size_e size;
  assign kind = acc_kind_e'(req_kind);
  assign size = acc_size_e'(req_size);

  // ---------------- region select
  logic          hit;
  logic [IW-1:0] idx;

  region_match #(
    .AW(AW), .NREG(NREG), .IW(IW), .BASES(REG_BASE), .MASKS(REG_MASK)
  ) u_match (
    .clk(clk), .rst(rst), .addr(req_addr), .hit(hit), .idx(idx)
  );

  // ---------------- permission gate
  logic [PERM_W-1:0] perm;
  logic allowed, grant, err_now, is_store;

  assign perm = REG_PERM[idx];
  always_comb begin
    case (kind)
      ACC_WRITE:   allowed = perm[PERM_WR];
      ACC_FETCH:   allowed = perm[PERM_EX];
      ACC_IMGLOAD: allowed = perm[PERM_LD];
      default:     allowed = 1'b1;
    endcase
  end

  assign is_store = (kind == ACC_WRITE) || (kind == ACC_IMGLOAD);
  assign grant    = req_valid && hit && allowed;
  assign err_now  = req_valid && !(hit && allowed);

  assign slv_sel = grant ? (NREG'(1) << idx) : '0;
  assign slv_we  = grant && is_store;

  // ---------------- offset and alignment
  logic [AW-1:0] raw_off;
  assign raw_off = hit ? (req_addr & ~REG_MASK[idx]) : '0;

  always_comb begin
    case (size)
      SZ_BYTE: slv_offset = raw_off;
      SZ_HALF: slv_offset = {raw_off[AW-1:1], 1'b0};
      default: slv_offset = {raw_off[AW-1:LW], {LW{1'b0}}};
    endcase
  end

  // ---------------- store lanes
  wr_lanes #(.DW(DW)) u_wr (
    .clk(clk), .rst(rst), .en(slv_we), .size(size),
    .lo(req_addr[LW-1:0]), .din(req_wdata),
    .dout(slv_wdata), .be(slv_be)
  );

  // ---------------- response pipeline
  logic          q_valid, q_err, q_load;
  logic [IW-1:0] q_idx;
  logic [LW-1:0] q_lo;
  acc_size_e     q_size;
  logic          err_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid   <= 1'b0;
      q_err     <= 1'b0;
      q_load    <= 1'b0;
      q_idx     <= '0;
      q_lo      <= '0;
      q_size    <= SZ_WORD;
      err_flag  <= 1'b0;
      err_rdata <= 1'b0;
    end else begin
      q_valid   <= req_valid;
      q_err     <= err_now;
      q_load    <= grant && !is_store;
      q_idx     <= idx;
      q_lo      <= req_addr[LW-1:0];
      q_size    <= size;
      err_flag  <= (err_flag && !err_read) || err_now;
      err_rdata <= err_read && err_flag;
    end
  end

  logic [DW-1:0] sel_word, steered;
  assign sel_word = slv_rdata[int'(q_idx) * DW +: DW];

  rd_lanes #(.DW(DW)) u_rd (
    .size(q_size), .lo(q_lo), .word(sel_word), .dout(steered)
  );

  assign rsp_valid = q_valid;
  assign rsp_err   = q_valid && q_err;
  assign rsp_data  = (q_valid && q_load) ? steered : '0;

  // R9: one response per request, one cycle later
  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R3: error responses carry no data
  assert_err_nodata_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_data == '0));
  // R4: refused or unmapped requests touch no slave
  assert_err_nosel_R4: assert property (@(posedge clk) disable iff (rst)
    err_now |-> (slv_sel == '0 && !slv_we));
  // R10: a read with no new error leaves the flag clear
  assert_flag_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (err_read && !err_now) |=> !err_flag);
  // R10: any error response leaves the flag set
  assert_flag_sets_R10: assert property (@(posedge clk) disable iff (rst)
    err_now |=> err_flag);
  // R2: the offset never carries bits the region mask decodes
  assert_offset_local_R2: assert property (@(posedge clk) disable iff (rst)
    hit |-> ((slv_offset & REG_MASK[idx]) == '0));
endmodule

// File: tb/bus_region_decoder_tb.sv
`timescale 1ns/1ps
module bus_region_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        err_read = 1'b0;
  logic [3:0]  slv_sel;
  logic        slv_we;
  logic [31:0] slv_offset, slv_wdata, rsp_data;
  logic [3:0]  slv_be;
  logic [127:0] slv_rdata;
  logic        rsp_valid, rsp_err, err_rdata;

  bus_region_decoder u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .slv_sel(slv_sel), .slv_we(slv_we), .slv_offset(slv_offset),
    .slv_wdata(slv_wdata), .slv_be(slv_be), .slv_rdata(slv_rdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .err_read(err_read), .err_rdata(err_rdata)
  );

  // slave word memories with one cycle of read latency
  logic [31:0] mem [0:3][0:15];
  logic [31:0] rq  [0:3];
  always @(posedge clk) begin
    for (int s = 0; s < 4; s++) begin
      if (rst) begin
        for (int w = 0; w < 16; w++)
          mem[s][w] <= {8'hA0 + 8'(s), 8'h10 + 8'(w), 8'h5A, 8'h3C};
        rq[s] <= '0;
      end else begin
        rq[s] <= mem[s][slv_offset[5:2]];
        if (slv_sel[s] && slv_we)
          for (int b = 0; b < 4; b++)
            if (slv_be[b]) mem[s][slv_offset[5:2]][8*b +: 8] <= slv_wdata[8*b +: 8];
      end
    end
  end
  assign slv_rdata = {rq[3], rq[2], rq[1], rq[0]};

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  xsel;
    logic [3:0]  xbe;
    logic [31:0] xoff;
    logic [31:0] xwd;
    logic        xerr;
    logic [31:0] xdata;
  } vec_t;

  localparam int NV = 24;
  // kinds: 0 read 1 write 2 fetch 3 image load; sizes: 0 byte 1 half 2 word
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd2, 32'h0002_0010, 32'h0, 4'b0010, 4'b0000, 32'h10, 32'h0, 1'b0, 32'hA114_5A3C},
    '{2'd0, 2'd0, 32'h0002_0011, 32'h0, 4'b0010, 4'b0000, 32'h11, 32'h0, 1'b0, 32'h0000_0014},
    '{2'd0, 2'd0, 32'h0002_0013, 32'h0, 4'b0010, 4'b0000, 32'h13, 32'h0, 1'b0, 32'h0000_003C},
    '{2'd0, 2'd1, 32'h0002_0012, 32'h0, 4'b0010, 4'b0000, 32'h12, 32'h0, 1'b0, 32'h0000_5A3C},
    '{2'd0, 2'd1, 32'h0002_0011, 32'h0, 4'b0010, 4'b0000, 32'h10, 32'h0, 1'b0, 32'h0000_A114},
    '{2'd1, 2'd0, 32'h0002_0005, 32'hEE, 4'b0010, 4'b0100, 32'h05, 32'hEEEE_EEEE, 1'b0, 32'h0},
    '{2'd0, 2'd2, 32'h0002_0004, 32'h0, 4'b0010, 4'b0000, 32'h04, 32'h0, 1'b0, 32'hA1EE_5A3C},
    '{2'd1, 2'd1, 32'h0002_0006, 32'hBEEF, 4'b0010, 4'b0011, 32'h06, 32'hBEEF_BEEF, 1'b0, 32'h0},
    '{2'd0, 2'd2, 32'h0002_0004, 32'h0, 4'b0010, 4'b0000, 32'h04, 32'h0, 1'b0, 32'hA1EE_BEEF},
    '{2'd1, 2'd2, 32'h1000_0008, 32'h1234_5678, 4'b1000, 4'b1111, 32'h08, 32'h1234_5678, 1'b0, 32'h0},
    '{2'd0, 2'd2, 32'h1000_0008, 32'h0, 4'b1000, 4'b0000, 32'h08, 32'h0, 1'b0, 32'h1234_5678},
    '{2'd0, 2'd2, 32'h1002_0004, 32'h0, 4'b0010, 4'b0000, 32'h1000_0004, 32'h0, 1'b0, 32'hA1EE_BEEF},
    '{2'd0, 2'd2, 32'h0000_0200, 32'h0, 4'b0000, 4'b0000, 32'h0, 32'h0, 1'b1, 32'h0},
    '{2'd1, 2'd2, 32'h0100_0004, 32'hDEAD_BEEF, 4'b0000, 4'b0000, 32'h04, 32'h0, 1'b1, 32'h0},
    '{2'd0, 2'd2, 32'h0100_0004, 32'h0, 4'b0100, 4'b0000, 32'h04, 32'h0, 1'b0, 32'hA211_5A3C},
    '{2'd2, 2'd2, 32'h0000_0154, 32'h0, 4'b0000, 4'b0000, 32'h04, 32'h0, 1'b1, 32'h0},
    '{2'd2, 2'd2, 32'h0100_0008, 32'h0, 4'b0100, 4'b0000, 32'h08, 32'h0, 1'b0, 32'hA212_5A3C},
    '{2'd3, 2'd2, 32'h0100_000C, 32'hCAFE_F00D, 4'b0100, 4'b1111, 32'h0C, 32'hCAFE_F00D, 1'b0, 32'h0},
    '{2'd0, 2'd2, 32'h0100_000C, 32'h0, 4'b0100, 4'b0000, 32'h0C, 32'h0, 1'b0, 32'hCAFE_F00D},
    '{2'd3, 2'd2, 32'h0000_0150, 32'h1111_1111, 4'b0000, 4'b0000, 32'h00, 32'h0, 1'b1, 32'h0},
    '{2'd1, 2'd0, 32'h0000_0153, 32'h41, 4'b0001, 4'b0001, 32'h03, 32'h4141_4141, 1'b0, 32'h0},
    '{2'd0, 2'd0, 32'h0000_0153, 32'h0, 4'b0001, 4'b0000, 32'h03, 32'h0, 1'b0, 32'h0000_0041},
    '{2'd0, 2'd2, 32'h0000_0150, 32'h0, 4'b0001, 4'b0000, 32'h00, 32'h0, 1'b0, 32'hA010_5A41},
    '{2'd2, 2'd2, 32'h1000_0008, 32'h0, 4'b1000, 4'b0000, 32'h08, 32'h0, 1'b0, 32'h1234_5678}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R11 err_rdata after reset", 32'(err_rdata), 32'd0);
    err_read = 1'b1;
    @(negedge clk);
    err_read = 1'b0;
    chk("R11 flag clear after reset", 32'(err_rdata), 32'd0);

    // table walk: request-cycle outputs, then the response one cycle later
    for (int k = 0; k < NV; k++) begin
      req_valid = 1'b1;
      req_kind  = VECS[k].kind;
      req_size  = VECS[k].size;
      req_addr  = VECS[k].addr;
      req_wdata = VECS[k].wdata;
      #1;
      chk($sformatf("R1/R3/R4 sel v%0d", k), 32'(slv_sel), 32'(VECS[k].xsel));
      chk($sformatf("R2 offset v%0d", k), slv_offset, VECS[k].xoff);
      chk($sformatf("R8 be v%0d", k), 32'(slv_be), 32'(VECS[k].xbe));
      chk($sformatf("R8 we v%0d", k), 32'(slv_we), 32'(|VECS[k].xbe));
      if (|VECS[k].xbe)
        chk($sformatf("R7 wdata v%0d", k), slv_wdata, VECS[k].xwd);
      @(negedge clk);
      chk($sformatf("R9 rsp_valid v%0d", k), 32'(rsp_valid), 32'd1);
      chk($sformatf("R3/R4 rsp_err v%0d", k), 32'(rsp_err), 32'(VECS[k].xerr));
      chk($sformatf("R5/R6/R9 rsp_data v%0d", k), rsp_data, VECS[k].xdata);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9 no response when idle", 32'(rsp_valid), 32'd0);

    // R10: flag was set by table errors; read returns it and clears it
    err_read = 1'b1;
    @(negedge clk);
    err_read = 1'b0;
    chk("R10 read returns set flag", 32'(err_rdata), 32'd1);
    err_read = 1'b1;
    @(negedge clk);
    err_read = 1'b0;
    chk("R10 flag cleared by read", 32'(err_rdata), 32'd0);

    // R10: good access does not set the flag
    req_valid = 1'b1; req_kind = 2'd0; req_size = 2'd2; req_addr = 32'h0002_0000;
    @(negedge clk);
    req_valid = 1'b0;
    err_read = 1'b1;
    @(negedge clk);
    err_read = 1'b0;
    chk("R10 good access leaves flag clear", 32'(err_rdata), 32'd0);

    // R10: error in the same cycle as the read survives it
    req_valid = 1'b1; req_kind = 2'd0; req_addr = 32'h0000_0300;
    err_read = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 read sees old flag", 32'(err_rdata), 32'd0);
    chk("R3 unmapped response error", 32'(rsp_err), 32'd1);
    err_read = 1'b1;
    @(negedge clk);
    err_read = 1'b0;
    chk("R10 same-cycle error kept", 32'(err_rdata), 32'd1);

    // R4: refused store left the flash word untouched (read back)
    req_valid = 1'b1; req_kind = 2'd0; req_size = 2'd2; req_addr = 32'h0100_0004;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R4 refused store wrote nothing", rsp_data, 32'hA211_5A3C);

    // R1: UART window edge is exclusive
    req_valid = 1'b1; req_addr = 32'h0000_0160;
    #1;
    chk("R1 address past window unmapped", 32'(slv_sel), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 past window error", 32'(rsp_err), 32'd1);

    @(negedge clk);
    finish_run();
  end
endmodule